// File: doc/BRIEF.md
# Gated Duplication Error Checker

This block computes a small ALU function (add, subtract, AND, XOR) on two operands and keeps a second copy of the same logic beside it. In each cycle where checking is active, both copies work on the same operands and their results are compared. A difference raises a one-cycle error pulse in the next cycle and sets a sticky error bit. The duplicate copy is not always active. A 16-bit LFSR runs freely, and checking is active only in cycles where the LFSR state agrees with a programmable pattern on the bit positions chosen by a programmable mask. In all other cycles the duplicate's operand registers keep their last values, so the duplicate logic does not switch.

Software uses the mask width to trade power against error coverage. Each extra mask bit roughly halves the fraction of cycles that are checked. A saturating counter reports how many cycles were actually checked. A global disable input turns checking off entirely. A fault-injection input flips bit 0 of the main result, so that detection can be shown in active cycles and silence in inactive ones.

Top module: `gated_dup_checker`

## Requirements
- R1: `result` is the combinational ALU output of `in_a`, `in_b`, taken modulo 2^DATA_W. `in_op` selects the operation: 0 is a+b, 1 is a-b, 2 is a AND b, 3 is a XOR b. While `inject_fault` is 1, bit 0 of this value is inverted.
- R2: The LFSR state is 0x0001 after reset. It shifts left every cycle, and the new bit 0 is the XOR of state bits 15, 13, 12 and 10. A configuration write with `cfg_sel`=0 loads `cfg_data` as the state at the next edge, replacing the shift for that cycle. A written value of zero is loaded as 0x0001.
- R3: `chk_active` is 1 in a cycle exactly when ((state XOR pattern) AND mask) is zero and `chk_disable` is 0. `cfg_sel`=1 writes the mask and `cfg_sel`=2 writes the pattern; each takes effect from the next cycle. Both reset to zero, so checking is active in every cycle after reset.
- R4: While `chk_disable` is 1, `chk_active` is 0, no error is raised and the coverage counter does not move.
- R5: `err_pulse` is 1 in the cycle after an active cycle in which the main and duplicate results differ, and is 0 after an active cycle in which they agree.
- R6: `err_pulse` is 0 in the cycle after an inactive cycle, even if the main result was wrong.
- R7: In inactive cycles the duplicate copy's operands hold their previous values. Operand changes made while checking is off never cause an error when checking resumes.
- R8: `err_sticky` goes to 1 together with `err_pulse` and stays at 1 until a write with `cfg_sel`=3 clears it. If a clear write and a new detection fall in the same cycle, the detection wins and the bit stays 1.
- R9: `cov_count` is zero after reset and adds one after every active cycle. It saturates at 2^CNT_W-1; CNT_W defaults to 32.
- R10: After reset, `err_pulse`, `err_sticky` and `cov_count` are 0, and `chk_active` is 1 while `chk_disable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| in_op | input | 2 | Operation select |
| inject_fault | input | 1 | Flips bit 0 of the main result |
| result | output | DATA_W | Main-copy result |
| chk_disable | input | 1 | Global checking disable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 seed, 1 mask, 2 pattern, 3 clear sticky |
| cfg_data | input | 16 | Configuration write data |
| chk_active | output | 1 | Checking is active in this cycle |
| err_pulse | output | 1 | Mismatch seen in the previous active cycle |
| err_sticky | output | 1 | Latched error, cleared by a write |
| cov_count | output | CNT_W | Number of checked cycles, saturating |

## Verification
Two events can fall in the same cycle: a detected mismatch and a software clear of the sticky bit. The bench holds fault injection high with the mask at zero and issues the clear write in that same cycle. It then expects the sticky bit still set one cycle later, and clears it in a following cycle with the fault removed to show that the clear does work. A second overlap is a mask or pattern write arriving while the LFSR advances. The bench model applies each configuration change from the next cycle and compares `chk_active` against its own prediction in every cycle.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    CFG_SEED    = 2'd0,
    CFG_MASK    = 2'd1,
    CFG_PATTERN = 2'd2,
    CFG_CLEAR   = 2'd3
  } cfg_sel_e;

  // one shift of the maximal-length generator x^16+x^14+x^13+x^11+1
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[LFSR_W-2:0], fb};
  endfunction

  // the all-zero state would lock the generator
  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
    return (s == '0) ? LFSR_W'(1) : s;
  endfunction
endpackage

// File: rtl/gdc_alu.sv
module gdc_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] y
);
  import gdc_pkg::*;

  always_comb begin
    unique case (alu_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/gdc_lfsr.sv
module gdc_lfsr (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [gdc_pkg::LFSR_W-1:0]  seed,
  output logic [gdc_pkg::LFSR_W-1:0]  state
);
  import gdc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= LFSR_W'(1);
    else if (load) state <= seed_fix(seed);
    else           state <= lfsr_step(state);
  end
endmodule

// File: rtl/gdc_dup_path.sv
module gdc_dup_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] dup_a,
  output logic [W-1:0] dup_b,
  output logic [1:0]   dup_op,
  output logic [W-1:0] dup_res
);
  logic [W-1:0] a_q, b_q;
  logic [1:0]   op_q;

  // operand holders load only in checked cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= '0;
    end else if (enable) begin
      a_q  <= a;
      b_q  <= b;
      op_q <= op;
    end
  end

  assign dup_a  = enable ? a  : a_q;
  assign dup_b  = enable ? b  : b_q;
  assign dup_op = enable ? op : op_q;

  gdc_alu #(.W(W)) u_dup_alu (
    .a  (dup_a),
    .b  (dup_b),
    .op (dup_op),
    .y  (dup_res)
  );
endmodule

// File: rtl/gdc_cov_cnt.sv
module gdc_cov_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (inc && count != CNT_MAX)  count <= count + 1'b1;
  end
endmodule

// File: rtl/gated_dup_checker.sv
module gated_dup_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_op,
  input  logic              inject_fault,
  output logic [DATA_W-1:0] result,
  input  logic              chk_disable,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [15:0]       cfg_data,
  output logic              chk_active,
  output logic              err_pulse,
  output logic              err_sticky,
  output logic [CNT_W-1:0]  cov_count
);
  import gdc_pkg::*;

  logic [LFSR_W-1:0] lfsr_q, mask_q, pat_q;
  logic              seed_wr, mask_wr, pat_wr, clear_wr;
  logic              cond_match;
  logic [DATA_W-1:0] main_raw, dup_res;
  logic [DATA_W-1:0] dup_a, dup_b;
  logic [1:0]        dup_op;
  logic              mismatch_raw, detect;

  assign seed_wr  = cfg_we && (cfg_sel == CFG_SEED);
  assign mask_wr  = cfg_we && (cfg_sel == CFG_MASK);
  assign pat_wr   = cfg_we && (cfg_sel == CFG_PATTERN);
  assign clear_wr = cfg_we && (cfg_sel == CFG_CLEAR);

  gdc_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_wr),
    .seed  (cfg_data),
    .state (lfsr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pat_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= cfg_data;
      if (pat_wr)  pat_q  <= cfg_data;
    end
  end

  assign cond_match = ((lfsr_q ^ pat_q) & mask_q) == '0;
  assign chk_active = cond_match && !chk_disable;

  gdc_alu #(.W(DATA_W)) u_main_alu (
    .a  (in_a),
    .b  (in_b),
    .op (in_op),
    .y  (main_raw)
  );

  assign result = main_raw ^ DATA_W'(inject_fault);

  gdc_dup_path #(.W(DATA_W)) u_dup (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (chk_active),
    .a       (in_a),
    .b       (in_b),
    .op      (in_op),
    .dup_a   (dup_a),
    .dup_b   (dup_b),
    .dup_op  (dup_op),
    .dup_res (dup_res)
  );

  assign mismatch_raw = (result != dup_res);
  assign detect       = chk_active && mismatch_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse <= detect;
      if (detect)        err_sticky <= 1'b1;
      else if (clear_wr) err_sticky <= 1'b0;
    end
  end

  gdc_cov_cnt #(.CNT_W(CNT_W)) u_cov (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (chk_active),
    .count (cov_count)
  );
endmodule

// File: rtl/gdc_checker.sv
module gdc_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_disable,
  input logic              chk_active,
  input logic [15:0]       mask_q,
  input logic              mismatch_raw,
  input logic              err_pulse,
  input logic              err_sticky,
  input logic [CNT_W-1:0]  cov_count,
  input logic [DATA_W-1:0] dup_a,
  input logic [DATA_W-1:0] dup_b,
  input logic [1:0]        dup_op
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_open_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !chk_disable) |-> chk_active);

  p_global_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_disable |-> !chk_active);

  p_detect_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_active && mismatch_raw) |=> err_pulse);

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_active |=> !err_pulse);

  p_frozen_operands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !chk_active) |-> ($stable(dup_a) && $stable(dup_b) && $stable(dup_op)));

  p_sticky_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  p_cov_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_active && cov_count != CMAX) |=> cov_count == $past(cov_count) + 1'b1);

  p_cov_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_active |=> $stable(cov_count));
endmodule

bind gated_dup_checker gdc_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_gdc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chk_disable  (chk_disable),
  .chk_active   (chk_active),
  .mask_q       (mask_q),
  .mismatch_raw (mismatch_raw),
  .err_pulse    (err_pulse),
  .err_sticky   (err_sticky),
  .cov_count    (cov_count),
  .dup_a        (dup_a),
  .dup_b        (dup_b),
  .dup_op       (dup_op)
);

// File: tb/gated_dup_checker_tb_top.sv
`timescale 1ns/100ps
module gated_dup_checker_tb_top;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] a = '0, b = '0;
  logic [1:0]    op = '0;
  logic          inj = 1'b0, dis = 1'b0, we = 1'b0;
  logic [1:0]    sel = '0;
  logic [15:0]   data = '0;
  logic [DW-1:0] result;
  logic          chk_active, err_pulse, err_sticky;
  logic [CW-1:0] cov_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] m_lfsr = 16'h0001, m_mask = '0, m_pat = '0;
  logic        m_err = 0, m_sticky = 0;
  int          m_cov = 0;

  always #2.5 clk = ~clk;

  gated_dup_checker #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_a(a), .in_b(b), .in_op(op),
    .inject_fault(inj), .result(result), .chk_disable(dis),
    .cfg_we(we), .cfg_sel(sel), .cfg_data(data),
    .chk_active(chk_active), .err_pulse(err_pulse),
    .err_sticky(err_sticky), .cov_count(cov_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] ref_alu(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                            input logic [1:0] o);
    case (o)
      2'd0: return x + y;
      2'd1: return x + ~y + 1'b1;
      2'd2: return ~(~x | ~y);
      default: return (x | y) & ~(x & y);
    endcase
  endfunction

  function automatic logic [15:0] ref_next(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  // one clock: combinational checks, edge, model update, registered checks
  task automatic cyc(input string en_tag = "R3", input string err_tag = "");
    logic en;
    logic [DW-1:0] exp_res;
    #1;
    en = !dis && (((m_lfsr ^ m_pat) & m_mask) == 16'h0);
    exp_res = ref_alu(a, b, op) ^ {{(DW-1){1'b0}}, inj};
    check("R1", result, exp_res);
    check(dis ? "R4" : en_tag, chk_active, en);
    @(posedge clk);
    if (we && sel == 2'd0) m_lfsr = (data == 0) ? 16'h0001 : data;
    else                   m_lfsr = ref_next(m_lfsr);
    if (we && sel == 2'd1) m_mask = data;
    if (we && sel == 2'd2) m_pat  = data;
    m_err = en && inj;
    m_sticky = m_err || (m_sticky && !(we && sel == 2'd3));
    if (en && m_cov != CMAX) m_cov++;
    @(negedge clk);
    check(err_tag != "" ? err_tag : (dis ? "R4" : (en ? "R5" : "R6")), err_pulse, m_err);
    check("R8", err_sticky, m_sticky);
    check("R9", cov_count, m_cov);
    we = 0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [15:0] d, input string tag = "R3");
    we = 1; sel = s; data = d;
    cyc(tag);
  endtask

  task automatic t_reset();
    #1;
    check("R10", err_pulse, 0);
    check("R10", err_sticky, 0);
    check("R10", cov_count, 0);
    check("R10", chk_active, 1);
  endtask

  task automatic t_alu_modes();
    for (int i = 0; i < 24; i++) begin
      a = DW'(i * 37 + 200); b = DW'(i * 91 + 5); op = 2'(i);
      cyc("R3");
    end
    a = '1; b = 8'h01; op = 2'd0; cyc("R3");
    a = 8'h00; b = 8'h01; op = 2'd1; cyc("R3");
  endtask

  task automatic t_detect_and_clear();
    inj = 1; a = 8'h3C; b = 8'h41; op = 2'd0;
    cyc("R3", "R5");
    check("R5", err_pulse, 1);
    we = 1; sel = 2'd3; data = '0;
    cyc("R3", "R8");
    check("R8", err_sticky, 1);
    inj = 0;
    cfg(2'd3, 16'h0);
    check("R8", err_sticky, 0);
    cyc("R3", "R5");
  endtask

  task automatic t_lfsr_match();
    cfg(2'd1, 16'h000F, "R2");
    cfg(2'd2, 16'h0005, "R2");
    cfg(2'd0, 16'hACE1, "R2");
    for (int i = 0; i < 64; i++) begin
      a = DW'(i); b = DW'(3 * i); op = 2'(i >> 1);
      cyc("R2");
    end
    cfg(2'd1, 16'hFFFF, "R2");
    cfg(2'd2, 16'h0002, "R2");
    cfg(2'd0, 16'h0000, "R2");
    cyc("R2");
    check("R2", chk_active, 1);
    cyc("R2");
  endtask

  task automatic t_partial_inject();
    cfg(2'd1, 16'h0003);
    cfg(2'd2, 16'h0000);
    inj = 1;
    for (int i = 0; i < 40; i++) begin
      a = DW'(i * 5); b = DW'(i * 11); op = 2'(i);
      cyc("R3");
    end
    inj = 0;
    cfg(2'd3, 16'h0);
  endtask

  task automatic t_freeze();
    for (int i = 0; i < 40; i++) begin
      a = DW'(i * 29 + 7); b = DW'(i * 13 + 100); op = 2'(i + 1);
      cyc("R3", "R7");
    end
  endtask

  task automatic t_disable();
    int cov_before;
    dis = 1; inj = 1;
    cov_before = m_cov;
    for (int i = 0; i < 6; i++) begin
      a = DW'(i); cyc("R4", "R4");
    end
    check("R4", cov_count, cov_before);
    dis = 0; inj = 0;
  endtask

  task automatic t_saturate();
    cfg(2'd1, 16'h0000);
    for (int i = 0; i < 300; i++) cyc("R3");
    check("R9", cov_count, CMAX);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_alu_modes();
    t_detect_and_clear();
    t_lfsr_match();
    t_partial_inject();
    t_freeze();
    t_disable();
    t_saturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule